// File: doc/BRIEF.md
# Compare-Match Timer Channel

This block is one up-counting timer channel. A slow reference clock arrives asynchronously. It is synchronized into the bus clock domain, and a selectable divider turns its rising edges into count ticks. On every tick the counter is compared against a programmable compare value. When they are equal, the channel latches a match status flag. In periodic mode the counter also restarts from zero, so one period is the compare value plus one ticks. In free-running mode the counter keeps incrementing. It wraps past all ones, and that wrap latches an overflow flag when no match occurred on the same tick.

Software uses three word-indexed registers: a 16-bit control/status word, the counter and the compare value. Counting is gated by an external start/stop input. That input comes from a start register shared with other channels. Stopping and restarting the channel leaves the counter and both flags intact.

A counter write does not take effect at once. The written value is held, and a write-pending status bit is raised. The held value is loaded into the counter on the second synchronized reference edge after the write, and the pending bit then drops. The interrupt line follows the match flag whenever the interrupt enable is set and the request kind selects an interrupt.

Top module: `cmt_channel`

## Requirements
- R1: After reset, the control/status word reads 0, the counter reads 0, the compare register reads all ones and `irq` is low.
- R2: `bus_idx` selects the register that `bus_rdata` returns and that a write updates: 0 is control/status, 1 is the counter, 2 is the compare value, and 3 reads as zero. In the control/status word:
  - bit 15 is the match flag and bit 14 the overflow flag;
  - bit 13 is write-pending and is read-only;
  - bit 8 selects periodic mode and bit 7 enables the interrupt;
  - bits 5:4 hold the request kind and bits 2:0 the clock select;
  - all other bits read 0.
- R3: A counter write raises bit 13 at once while the counter keeps reading its old value. The value is loaded on the second synchronized rising edge of `ref_clk` after the write, and bit 13 then clears. This works whether the channel is running or stopped.
- R4: In periodic mode, a tick that finds the counter equal to the compare value reloads the counter with 0. The counter therefore repeats with a period of compare+1 ticks, and no overflow is flagged even when the compare value is all ones.
- R5: Any tick that finds the counter equal to the compare value sets the match flag.
- R6: `irq` is high exactly while the match flag is 1, bit 7 is 1 and bits 5:4 equal 2. A request kind of 0, 1 or 3 keeps `irq` low.
- R7: A control/status write with bit 15 (or bit 14) at 0 clears that flag. Writing 1 leaves the flag unchanged and never sets it. A flag event in the same cycle as a clearing write wins.
- R8: While `run_en` is low the counter holds its value, the divider is cleared and both flags are kept. Raising `run_en` resumes counting from the held value.
- R9: With `run_en` high, clock select 7 counts every `ref_clk` rising edge. Clock selects 4, 5 and 6 count once every 8, 32 and 128 edges, the first tick falling on the 8th, 32nd or 128th edge after the start. Codes 0 to 3 produce no ticks.
- R10: The overflow flag sets when a tick moves the counter from all ones to 0 without a match.
- R11: In free-running mode (bit 8 = 0) the counter keeps incrementing after a match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_clk | input | 1 | Slow reference clock, asynchronous to clk |
| run_en | input | 1 | Start/stop gate for this channel |
| bus_wr | input | 1 | Register write strobe |
| bus_idx | input | 2 | Register index |
| bus_wdata | input | CNT_W (32) | Write data (bits 15:0 for control/status) |
| bus_rdata | output | CNT_W (32) | Read data for the selected register |
| irq | output | 1 | Interrupt request, level |

## Verification
A wrong divider state or synchronizer state shows up as a counter value that is one tick early or late. This appears at the first read taken mid-period after the affected reference edge, and it shows most clearly at the 7/8, 31/32 and 127/128 edge boundaries. A wrong pending count shows as a counter value that appears one reference period too early or too late, and bit 13 betrays it in the same read. A stuck or mis-set flag reaches `irq` in the same cycle. It also alters the periodic reload on the next match tick, so a bad wrap shows as a wrong counter value at most compare+1 ticks later.

// File: rtl/cmt_pkg.sv
`timescale 1ns/1ps
package cmt_pkg;

    localparam int CSR_W    = 16;
    localparam int B_MATCH  = 15;
    localparam int B_OVF    = 14;
    localparam int B_PEND   = 13;
    localparam int B_PER    = 8;
    localparam int B_IE     = 7;
    localparam int B_REQ_LO = 4;
    localparam int B_CKS_LO = 0;

    typedef enum logic [1:0] {
        REQ_NONE = 2'd0,
        REQ_DMA  = 2'd1,
        REQ_IRQ  = 2'd2,
        REQ_RSVD = 2'd3
    } req_kind_e;

    typedef enum logic [2:0] {
        CKS_DIV_A = 3'd4,
        CKS_DIV_B = 3'd5,
        CKS_DIV_C = 3'd6,
        CKS_RAW   = 3'd7
    } cks_code_e;

    typedef struct packed {
        logic       match;
        logic       ovf;
        logic       periodic;
        logic       ie;
        logic [1:0] req;
        logic [2:0] cks;
    } csr_t;

endpackage

// File: rtl/cmt_refsync.sv
`timescale 1ns/1ps
module cmt_refsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ref_clk,
    output logic ref_rise
);

    typedef struct packed {
        logic [STAGES-1:0] sync;
        logic              last;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.sync = {st_q.sync[STAGES-2:0], ref_clk};
        st_d.last = st_q.sync[STAGES-1];
        ref_rise  = st_q.sync[STAGES-1] & ~st_q.last;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: a pulse marks one edge only, never two cycles running
    a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ref_rise |=> !ref_rise);

endmodule

// File: rtl/cmt_prescale.sv
`timescale 1ns/1ps
module cmt_prescale
    import cmt_pkg::*;
#(
    parameter int LOG_A = 3,
    parameter int LOG_B = 5,
    parameter int LOG_C = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_rise,
    input  logic       run,
    input  logic [2:0] cks,
    output logic       tick
);

    localparam int DIV_AB = (LOG_A > LOG_B) ? LOG_A : LOG_B;
    localparam int DIV_W  = (LOG_C > DIV_AB) ? LOG_C : DIV_AB;

    typedef struct packed {
        logic [DIV_W-1:0] div;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!run)          st_d.div = '0;
        else if (ref_rise) st_d.div = st_q.div + 1'b1;

        tick = 1'b0;
        if (run && ref_rise) begin
            case (cks)
                CKS_DIV_A: tick = &st_q.div[LOG_A-1:0];
                CKS_DIV_B: tick = &st_q.div[LOG_B-1:0];
                CKS_DIV_C: tick = &st_q.div[LOG_C-1:0];
                CKS_RAW:   tick = 1'b1;
                default:   tick = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R8/R9: right after a stop, a divided select cannot tick at once
    a_r9_no_tick_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && cks == CKS_DIV_A) |=> !(tick && cks == CKS_DIV_A));

    a_r9_tick_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && $past(!run)) |-> !tick);

endmodule

// File: rtl/cmt_counter.sv
`timescale 1ns/1ps
module cmt_counter #(
    parameter int W          = 32,
    parameter int PEND_EDGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ref_rise,
    input  logic         tick,
    input  logic         periodic,
    input  logic         cnt_wr,
    input  logic [W-1:0] wr_val,
    input  logic [W-1:0] cmp_val,
    output logic [W-1:0] cnt,
    output logic         pend,
    output logic         match_evt,
    output logic         wrap_evt
);

    localparam int AW = $clog2(PEND_EDGES + 1);
    localparam logic [AW-1:0] ACK_LAST = AW'(PEND_EDGES - 1);

    typedef struct packed {
        logic [W-1:0]  cnt;
        logic [W-1:0]  hold;
        logic          pend;
        logic [AW-1:0] ack;
    } st_t;

    st_t  st_d, st_q;
    logic apply;

    always_comb begin
        st_d      = st_q;
        match_evt = 1'b0;
        wrap_evt  = 1'b0;
        apply     = st_q.pend && ref_rise && (st_q.ack == ACK_LAST);

        // handover of a bus write into the slow counting timeline
        if (cnt_wr) begin
            st_d.hold = wr_val;
            st_d.pend = 1'b1;
            st_d.ack  = '0;
        end else if (st_q.pend && ref_rise) begin
            if (apply) begin
                st_d.pend = 1'b0;
                st_d.ack  = '0;
            end else begin
                st_d.ack = st_q.ack + 1'b1;
            end
        end

        if (apply) begin
            st_d.cnt = st_q.hold;
        end else if (tick) begin
            if (st_q.cnt == cmp_val) begin
                match_evt = 1'b1;
                st_d.cnt  = periodic ? '0 : st_q.cnt + 1'b1;
            end else if (&st_q.cnt) begin
                wrap_evt = 1'b1;
                st_d.cnt = '0;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt  = st_q.cnt;
    assign pend = st_q.pend;

    a_r3_pend_set: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_wr |=> pend);

    a_r3_load_on_apply: assert property (@(posedge clk) disable iff (!rst_n)
        apply |=> (cnt == $past(st_q.hold)));

    a_r4_periodic_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !apply && periodic && cnt == cmp_val) |=> (cnt == '0));

    a_r8_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !apply) |=> $stable(cnt));

endmodule

// File: rtl/cmt_channel.sv
`timescale 1ns/1ps
module cmt_channel
    import cmt_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2,
    parameter int PEND_EDGES  = 2,
    parameter int LOG_A       = 3,
    parameter int LOG_B       = 5,
    parameter int LOG_C       = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_clk,
    input  logic             run_en,
    input  logic             bus_wr,
    input  logic [1:0]       bus_idx,
    input  logic [CNT_W-1:0] bus_wdata,
    output logic [CNT_W-1:0] bus_rdata,
    output logic             irq
);

    localparam logic [1:0] IDX_CSR = 2'd0;
    localparam logic [1:0] IDX_CNT = 2'd1;
    localparam logic [1:0] IDX_CMP = 2'd2;

    typedef struct packed {
        csr_t             csr;
        logic [CNT_W-1:0] cmp;
    } st_t;

    st_t st_d, st_q;

    logic             ref_rise, tick, pend, match_evt, wrap_evt;
    logic             wr_csr, wr_cnt, wr_cmp;
    logic [CNT_W-1:0] cnt;
    logic [CSR_W-1:0] csr_word;

    assign wr_csr = bus_wr && (bus_idx == IDX_CSR);
    assign wr_cnt = bus_wr && (bus_idx == IDX_CNT);
    assign wr_cmp = bus_wr && (bus_idx == IDX_CMP);

    cmt_refsync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_clk  (ref_clk),
        .ref_rise (ref_rise)
    );

    cmt_prescale #(.LOG_A(LOG_A), .LOG_B(LOG_B), .LOG_C(LOG_C)) u_presc (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_rise (ref_rise),
        .run      (run_en),
        .cks      (st_q.csr.cks),
        .tick     (tick)
    );

    cmt_counter #(.W(CNT_W), .PEND_EDGES(PEND_EDGES)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_rise  (ref_rise),
        .tick      (tick),
        .periodic  (st_q.csr.periodic),
        .cnt_wr    (wr_cnt),
        .wr_val    (bus_wdata),
        .cmp_val   (st_q.cmp),
        .cnt       (cnt),
        .pend      (pend),
        .match_evt (match_evt),
        .wrap_evt  (wrap_evt)
    );

    always_comb begin
        st_d = st_q;
        if (wr_csr) begin
            st_d.csr.match    = st_q.csr.match & bus_wdata[B_MATCH];
            st_d.csr.ovf      = st_q.csr.ovf   & bus_wdata[B_OVF];
            st_d.csr.periodic = bus_wdata[B_PER];
            st_d.csr.ie       = bus_wdata[B_IE];
            st_d.csr.req      = bus_wdata[B_REQ_LO +: 2];
            st_d.csr.cks      = bus_wdata[B_CKS_LO +: 3];
        end
        if (match_evt) st_d.csr.match = 1'b1;
        if (wrap_evt)  st_d.csr.ovf   = 1'b1;
        if (wr_cmp)    st_d.cmp       = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.csr <= '0;
            st_q.cmp <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        csr_word = '0;
        csr_word[B_MATCH]         = st_q.csr.match;
        csr_word[B_OVF]           = st_q.csr.ovf;
        csr_word[B_PEND]          = pend;
        csr_word[B_PER]           = st_q.csr.periodic;
        csr_word[B_IE]            = st_q.csr.ie;
        csr_word[B_REQ_LO +: 2]   = st_q.csr.req;
        csr_word[B_CKS_LO +: 3]   = st_q.csr.cks;
        case (bus_idx)
            IDX_CSR: bus_rdata = {{(CNT_W-CSR_W){1'b0}}, csr_word};
            IDX_CNT: bus_rdata = cnt;
            IDX_CMP: bus_rdata = st_q.cmp;
            default: bus_rdata = '0;
        endcase
    end

    assign irq = st_q.csr.match && st_q.csr.ie && (st_q.csr.req == REQ_IRQ);

    a_r5_match_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.csr.match) |-> $past(match_evt));

    a_r10_ovf_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.csr.ovf) |-> $past(wrap_evt));

    a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_csr && !bus_wdata[B_MATCH] && !match_evt) |=> !st_q.csr.match);

    a_r8_stopped_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_en && !pend) |=> $stable(cnt));

    a_r2_cmp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_cmp |=> $stable(st_q.cmp));

endmodule

// File: tb/cmt_channel_bench.sv
`timescale 1ns/1ps
module cmt_channel_bench;

    logic        clk = 1'b0;
    logic        ref_clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run_en = 1'b0;
    logic        bus_wr = 1'b0;
    logic [1:0]  bus_idx = 2'd0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;
    always #128 ref_clk = ~ref_clk;

    cmt_channel u_cmt_channel (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_clk   (ref_clk),
        .run_en    (run_en),
        .bus_wr    (bus_wr),
        .bus_idx   (bus_idx),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] idx, input logic [31:0] v);
        @(negedge clk);
        bus_idx   = idx;
        bus_wdata = v;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd(input logic [1:0] idx, output logic [31:0] v);
        @(negedge clk);
        bus_idx = idx;
        #1;
        v = bus_rdata;
    endtask

    task automatic wait_ref(input int n);
        repeat (n) @(posedge ref_clk);
        #100;
    endtask

    task automatic set_run(input logic v);
        @(negedge clk);
        run_en = v;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rd(2'd0, v); chk("R1 csr after reset", v, 32'h0);
        rd(2'd1, v); chk("R1 counter after reset", v, 32'h0);
        rd(2'd2, v); chk("R1 compare after reset", v, 32'hFFFF_FFFF);
        chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    endtask

    task automatic t_regs();
        logic [31:0] v;
        wr(2'd0, 32'h0000_FFFF);
        rd(2'd0, v); chk("R2 csr layout, R7 write-one no set", v, 32'h0000_01B7);
        wr(2'd2, 32'h1234_5678);
        rd(2'd2, v); chk("R2 compare readback", v, 32'h1234_5678);
        rd(2'd3, v); chk("R2 index 3 reads zero", v, 32'h0);
        wr(2'd0, 32'h0);
        rd(2'd0, v); chk("R2 csr cleared", v, 32'h0);
    endtask

    task automatic t_pend();
        logic [31:0] v;
        wr(2'd0, 32'h0000_0007);
        wait_ref(1);
        wr(2'd1, 32'd5);
        rd(2'd1, v); chk("R3 counter old right after write", v, 32'h0);
        rd(2'd0, v); chk("R3 pending set", (v >> 13) & 32'h1, 32'h1);
        wait_ref(1);
        rd(2'd1, v); chk("R3 counter old after one edge", v, 32'h0);
        rd(2'd0, v); chk("R3 pending after one edge", (v >> 13) & 32'h1, 32'h1);
        wait_ref(1);
        rd(2'd1, v); chk("R3 counter loaded after two edges", v, 32'd5);
        rd(2'd0, v); chk("R3 pending cleared", (v >> 13) & 32'h1, 32'h0);
        wr(2'd1, 32'h0);
        wait_ref(3);
    endtask

    task automatic t_periodic();
        logic [31:0] v;
        wr(2'd0, 32'h0000_01A7);
        wr(2'd2, 32'd3);
        wait_ref(1);
        set_run(1'b1);
        wait_ref(2);
        rd(2'd1, v); chk("R4 count after 2 ticks", v, 32'd2);
        rd(2'd0, v); chk("R5 no match yet", (v >> 15) & 32'h1, 32'h0);
        chk("R6 irq low before match", {31'b0, irq}, 32'h0);
        wait_ref(1);
        rd(2'd1, v); chk("R4 count reaches compare", v, 32'd3);
        wait_ref(1);
        rd(2'd1, v); chk("R4 reload to zero on match", v, 32'd0);
        rd(2'd0, v); chk("R5 match flag set", (v >> 15) & 32'h1, 32'h1);
        chk("R6 irq high on match", {31'b0, irq}, 32'h1);
        wait_ref(4);
        rd(2'd1, v); chk("R4 period compare+1", v, 32'd0);
        wait_ref(1);
        rd(2'd1, v); chk("R4 next period starts", v, 32'd1);
        set_run(1'b0);
    endtask

    task automatic t_hold();
        logic [31:0] v;
        wait_ref(3);
        rd(2'd1, v); chk("R8 counter held while stopped", v, 32'd1);
        rd(2'd0, v); chk("R8 match flag kept while stopped", (v >> 15) & 32'h1, 32'h1);
        set_run(1'b1);
        wait_ref(1);
        rd(2'd1, v); chk("R8 resume from held value", v, 32'd2);
        set_run(1'b0);
    endtask

    task automatic t_irq_clear();
        logic [31:0] v;
        wr(2'd0, 32'h0000_8197);
        rd(2'd0, v); chk("R7 write one keeps flag", (v >> 15) & 32'h1, 32'h1);
        chk("R6 irq low for request kind 1", {31'b0, irq}, 32'h0);
        wr(2'd0, 32'h0000_8187);
        chk("R6 irq low for request kind 0", {31'b0, irq}, 32'h0);
        wr(2'd0, 32'h0000_81A7);
        chk("R6 irq high for request kind 2", {31'b0, irq}, 32'h1);
        wr(2'd0, 32'h0000_01A7);
        rd(2'd0, v); chk("R7 write zero clears flag", (v >> 15) & 32'h1, 32'h0);
        chk("R6 irq follows cleared flag", {31'b0, irq}, 32'h0);
        wr(2'd0, 32'h0000_81A7);
        rd(2'd0, v); chk("R7 write one does not set flag", (v >> 15) & 32'h1, 32'h0);
    endtask

    task automatic presc_case(input logic [31:0] code, input int edges, input string tag);
        logic [31:0] v;
        wr(2'd0, code);
        wr(2'd1, 32'h0);
        wait_ref(3);
        set_run(1'b1);
        wait_ref(edges - 1);
        rd(2'd1, v); chk({tag, " no tick one edge early"}, v, 32'd0);
        wait_ref(1);
        rd(2'd1, v); chk({tag, " first tick"}, v, 32'd1);
        set_run(1'b0);
    endtask

    task automatic t_presc();
        logic [31:0] v;
        wr(2'd2, 32'hFFFF_FFFF);
        presc_case(32'h4, 8, "R9 div8");
        presc_case(32'h5, 32, "R9 div32");
        presc_case(32'h6, 128, "R9 div128");
        presc_case(32'h7, 1, "R9 raw");
        wr(2'd0, 32'h0);
        wr(2'd1, 32'h0);
        wait_ref(3);
        set_run(1'b1);
        wait_ref(4);
        rd(2'd1, v); chk("R9 code 0 does not count", v, 32'd0);
        set_run(1'b0);
    endtask

    task automatic t_ovf();
        logic [31:0] v;
        wr(2'd0, 32'h0000_0007);
        wr(2'd2, 32'd2);
        wr(2'd1, 32'hFFFF_FFFE);
        wait_ref(3);
        set_run(1'b1);
        wait_ref(1);
        rd(2'd1, v); chk("R10 count at all ones", v, 32'hFFFF_FFFF);
        rd(2'd0, v); chk("R10 no overflow yet", (v >> 14) & 32'h1, 32'h0);
        wait_ref(1);
        rd(2'd1, v); chk("R10 wrap to zero", v, 32'h0);
        rd(2'd0, v); chk("R10 overflow flag set", (v >> 14) & 3, 32'h1);
        wait_ref(3);
        rd(2'd1, v); chk("R11 free-run passes compare", v, 32'd3);
        rd(2'd0, v); chk("R5 match in free-run", (v >> 15) & 32'h1, 32'h1);
        wait_ref(1);
        rd(2'd1, v); chk("R11 keeps incrementing", v, 32'd4);
        set_run(1'b0);
        wr(2'd0, 32'h0000_8007);
        rd(2'd0, v); chk("R7 clear overflow only", (v >> 14) & 3, 32'h2);
        // periodic with compare all ones: match, no overflow
        wr(2'd0, 32'h0000_0107);
        wr(2'd2, 32'hFFFF_FFFF);
        wr(2'd1, 32'hFFFF_FFFE);
        wait_ref(3);
        set_run(1'b1);
        wait_ref(2);
        rd(2'd1, v); chk("R4 reload at all-ones compare", v, 32'h0);
        rd(2'd0, v); chk("R4 match without overflow", (v >> 14) & 3, 32'h2);
        set_run(1'b0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_regs();
        t_pend();
        t_periodic();
        t_hold();
        t_irq_clear();
        t_presc();
        t_ovf();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #800000;
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog R1 run did not finish actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule